// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block walks a freshly powered SD memory card through the command exchange that takes it to the identified state with a relative card address assigned. It does not drive the card's command line itself. Instead it hands each command (index, 32-bit argument, expected response kind) to a separate serializer through an abstract command port, with a one-cycle strobe. It then waits for that serializer to report sent, response-done, CRC-fail or timeout, together with the returned command index and the response bits.

After a start request the sequencer sends the reset command, probes the card's interface condition to tell newer cards from older ones, and polls the operating-condition command (each one prefixed by the application-command prefix) until the card reports ready. It then reads the identification register and asks the card for its relative address. When it finishes it pulses done with the card type and address valid. If a step runs out of attempts it pulses error instead. Serialization, CRC generation, clock division and data transfers live elsewhere.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, cmd_valid_o, done_o and error_o are low, card_type_o is 0 and rca_o is 0.
- R2: A start_i pulse in idle raises cmd_valid_o one cycle later with index 0, argument 0 and response kind none (cmd_rsp_o = 0). The following command goes out only after cmd_sent_i. That command is index 8 with argument 0x1CC and response kind short (cmd_rsp_o = 1).
- R3: An index-8 reply counts as valid when rsp_done_i is high, crc_fail_i and timeout_i are low and rsp_idx_i = 8. If rsp_word_i bit 8 is set, the capacity-request flag is set and the sequence continues with index 55. If bit 8 is clear, the result is an error.
- R4: If 32 attempts at index 8 all fail, the card is taken as an older card with the capacity-request flag clear, and the sequence continues with index 55.
- R5: Index 55 is sent with argument 0 and a short response. Its reply must be valid with rsp_idx_i = 55 and rsp_word_i bit 5 set. Any other reply counts as a failed attempt.
- R6: Index 41 is sent with a short response. Its argument has bit 28 set, bit 30 equal to the capacity-request flag, and all other bits 0. Its reply is good when rsp_idx_i = 0x3F and either rsp_done_i or crc_fail_i is high without timeout_i.
- R7: A good index-41 reply with bit 31 clear makes the sequencer send index 55 again and then index 41 again. Each new pair starts with a fresh attempt budget.
- R8: A good index-41 reply with bit 31 set fixes the card type. Bit 30 set gives 3 (high capacity). Bit 30 clear gives 2 if the capacity-request flag is set, and 1 if it is clear.
- R9: Index 2 is sent with argument 0 and a long response (cmd_rsp_o = 3), and its reply must have rsp_idx_i = 0x3F. Index 3 is sent with argument 0 and a short response, its reply must have rsp_idx_i = 3, and rsp_o takes rsp_word_i bits 31:16.
- R10: The following each count as a failed attempt, and the same command is reissued: a timeout, a CRC failure on any command other than 41, and an index mismatch. A step allows up to 32 attempts.
- R11: Running out of attempts at index 55, 41, 2 or 3 pulses error_o for one cycle, returns the sequencer to idle, and clears card_type_o and rca_o.
- R12: On success done_o pulses for one cycle while card_type_o and rca_o hold the result. Both outputs keep their values until the next start.
- R13: cmd_valid_o is a one-cycle strobe. start_i is ignored while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin initialization (idle only) |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_rsp_o | output | 2 | Response kind: 0 none, 1 short, 3 long |
| cmd_sent_i | input | 1 | Command transmitted (no-response commands) |
| rsp_done_i | input | 1 | Response received with good CRC |
| crc_fail_i | input | 1 | Response received with bad CRC |
| timeout_i | input | 1 | No response in time |
| rsp_idx_i | input | 6 | Returned command index |
| rsp_word_i | input | 128 | Response bits; a short reply sits in 31:0 |
| done_o | output | 1 | Sequence completed (pulse) |
| error_o | output | 1 | Sequence failed (pulse) |
| card_type_o | output | 2 | 0 none, 1 older card, 2 newer standard, 3 newer high capacity |
| rca_o | output | 16 | Relative card address |

## Verification
Every result follows the stimulus that causes it by exactly one cycle. A start pulse brings the first strobe in the next cycle. A status pulse brings the next strobe, or done/error, in the cycle after the pulse, and done falls again one cycle later. The bench drives each status pulse on a falling edge after a random wait of 0 to 3 cycles. It then samples the strobe, done and error at the next falling edge, and requires one of them there. Each command's index, argument and response kind is checked against an order the bench derives from the replies it chose. The attempt limits are probed at exactly 31 and 32 failures.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;
  localparam int IDX_W = 6;
  localparam int ARG_W = 32;
  localparam int RCA_W = 16;
  localparam logic [IDX_W-1:0] IDX_ANY = 6'h3F;

  typedef enum logic [2:0] {ST_CMD0, ST_CMD8, ST_CMD55, ST_CMD41, ST_CMD2, ST_CMD3} step_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;

  localparam logic [1:0] RSP_NONE  = 2'd0;
  localparam logic [1:0] RSP_SHORT = 2'd1;
  localparam logic [1:0] RSP_LONG  = 2'd3;

  localparam logic [1:0] CARD_NONE  = 2'd0;
  localparam logic [1:0] CARD_V1    = 2'd1;
  localparam logic [1:0] CARD_V2_SC = 2'd2;
  localparam logic [1:0] CARD_V2_HC = 2'd3;

  function automatic logic [IDX_W-1:0] step_idx(step_e s);
    case (s)
      ST_CMD0:  return 6'd0;
      ST_CMD8:  return 6'd8;
      ST_CMD55: return 6'd55;
      ST_CMD41: return 6'd41;
      ST_CMD2:  return 6'd2;
      default:  return 6'd3;
    endcase
  endfunction
endpackage

// File: rtl/sd_cmd_drv.sv
module sd_cmd_drv import sd_init_pkg::*; (
  input  step_e             step_i,
  input  logic              hcs_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic [1:0]        rsp_o
);
  always_comb begin
    idx_o = step_idx(step_i);
    arg_o = '0;
    rsp_o = RSP_SHORT;
    case (step_i)
      ST_CMD0:  rsp_o = RSP_NONE;
      ST_CMD8:  arg_o = 32'h0000_01CC;
      ST_CMD41: begin
        arg_o[28] = 1'b1;
        arg_o[30] = hcs_i;
      end
      ST_CMD2:  rsp_o = RSP_LONG;
      default:  ;
    endcase
  end
endmodule

// File: rtl/sd_rsp_eval.sv
module sd_rsp_eval import sd_init_pkg::*; (
  input  step_e             step_i,
  input  logic              cmd_sent_i,
  input  logic              rsp_done_i,
  input  logic              crc_fail_i,
  input  logic              timeout_i,
  input  logic [IDX_W-1:0]  rsp_idx_i,
  output logic              ev_o,
  output logic              good_o
);
  logic [IDX_W-1:0] exp_idx;
  logic             crc_ok;

  // op-cond and identification replies carry no usable index
  assign exp_idx = (step_i == ST_CMD41 || step_i == ST_CMD2) ? IDX_ANY : step_idx(step_i);
  assign crc_ok  = (step_i == ST_CMD41);

  always_comb begin
    if (step_i == ST_CMD0) begin
      ev_o   = cmd_sent_i;
      good_o = cmd_sent_i;
    end else begin
      ev_o   = rsp_done_i | crc_fail_i | timeout_i;
      good_o = !timeout_i && (rsp_idx_i == exp_idx) &&
               (crc_fail_i ? crc_ok : rsp_done_i);
    end
  end
endmodule

// File: rtl/sd_try_cnt.sv
module sd_try_cnt #(
  parameter int MAX_TRY = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = (MAX_TRY > 2) ? $clog2(MAX_TRY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_TRY - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq import sd_init_pkg::*; #(
  parameter int MAX_TRY = 32,
  parameter int RSP_W   = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              cmd_valid_o,
  output logic [5:0]        cmd_idx_o,
  output logic [31:0]       cmd_arg_o,
  output logic [1:0]        cmd_rsp_o,
  input  logic              cmd_sent_i,
  input  logic              rsp_done_i,
  input  logic              crc_fail_i,
  input  logic              timeout_i,
  input  logic [5:0]        rsp_idx_i,
  input  logic [RSP_W-1:0]  rsp_word_i,
  output logic              done_o,
  output logic              error_o,
  output logic [1:0]        card_type_o,
  output logic [15:0]       rca_o
);
  phase_e           phase_q, phase_d;
  step_e            step_q, step_d;
  logic             hcs_q, hcs_d;
  logic [1:0]       type_q, type_d;
  logic [RCA_W-1:0] rca_q, rca_d;
  logic             done_q, done_d, err_q, err_d;
  logic             try_clr, try_inc, try_last;
  logic             ev, good, retry, abort;
  logic [31:0]      w;

  assign w = rsp_word_i[31:0];

  sd_cmd_drv u_drv (
    .step_i(step_q), .hcs_i(hcs_q),
    .idx_o(cmd_idx_o), .arg_o(cmd_arg_o), .rsp_o(cmd_rsp_o)
  );

  sd_rsp_eval u_eval (
    .step_i(step_q), .cmd_sent_i(cmd_sent_i), .rsp_done_i(rsp_done_i),
    .crc_fail_i(crc_fail_i), .timeout_i(timeout_i), .rsp_idx_i(rsp_idx_i),
    .ev_o(ev), .good_o(good)
  );

  sd_try_cnt #(.MAX_TRY(MAX_TRY)) u_try (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(try_clr), .inc_i(try_inc), .last_o(try_last)
  );

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    hcs_d   = hcs_q;
    type_d  = type_q;
    rca_d   = rca_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    try_clr = 1'b0;
    try_inc = 1'b0;
    retry   = 1'b0;
    abort   = 1'b0;
    case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_ISSUE;
        step_d  = ST_CMD0;
        hcs_d   = 1'b0;
        type_d  = CARD_NONE;
        rca_d   = '0;
        try_clr = 1'b1;
      end
      PH_ISSUE: phase_d = PH_WAIT;
      PH_WAIT: if (ev) begin
        phase_d = PH_ISSUE;
        if (!good) retry = 1'b1;
        else begin
          case (step_q)
            ST_CMD0: begin step_d = ST_CMD8; try_clr = 1'b1; end
            ST_CMD8: begin
              if (w[8]) begin hcs_d = 1'b1; step_d = ST_CMD55; try_clr = 1'b1; end
              else abort = 1'b1;
            end
            ST_CMD55: begin
              if (w[5]) begin step_d = ST_CMD41; try_clr = 1'b1; end
              else retry = 1'b1;
            end
            ST_CMD41: begin
              try_clr = 1'b1;
              if (w[31]) begin
                type_d = w[30] ? CARD_V2_HC : (hcs_q ? CARD_V2_SC : CARD_V1);
                step_d = ST_CMD2;
              end else step_d = ST_CMD55;  // card busy: new prefix + op-cond pair
            end
            ST_CMD2: begin step_d = ST_CMD3; try_clr = 1'b1; end
            default: begin
              rca_d   = w[31:16];
              done_d  = 1'b1;
              phase_d = PH_IDLE;
            end
          endcase
        end
      end
      default: phase_d = PH_IDLE;
    endcase

    if (retry) begin
      if (!try_last) try_inc = 1'b1;
      else if (step_q == ST_CMD8) begin  // no interface-condition reply: older card
        hcs_d   = 1'b0;
        step_d  = ST_CMD55;
        try_clr = 1'b1;
      end else abort = 1'b1;
    end
    if (abort) begin
      err_d   = 1'b1;
      phase_d = PH_IDLE;
      type_d  = CARD_NONE;
      rca_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_CMD0;
      hcs_q   <= 1'b0;
      type_q  <= CARD_NONE;
      rca_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      hcs_q   <= hcs_d;
      type_q  <= type_d;
      rca_q   <= rca_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cmd_valid_o = (phase_q == PH_ISSUE);
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign card_type_o = type_q;
  assign rca_o       = rca_q;
endmodule

// File: rtl/sd_init_seq_chk.sv
module sd_init_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_o,
  input logic [5:0]  cmd_idx_o,
  input logic [31:0] cmd_arg_o,
  input logic [1:0]  cmd_rsp_o,
  input logic        done_o,
  input logic        error_o,
  input logic [1:0]  card_type_o,
  input logic [15:0] rca_o
);
  assert_strobe_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_typed_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (card_type_o != 2'd0) && !error_o);

  assert_error_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (card_type_o == 2'd0) && (rca_o == 16'd0));

  assert_opcond_arg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_idx_o == 6'd41) |-> cmd_arg_o[28] && (cmd_rsp_o == 2'd1));

  assert_ident_long_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_idx_o == 6'd2) |-> (cmd_rsp_o == 2'd3));

  assert_reset_none_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_idx_o == 6'd0) |-> (cmd_rsp_o == 2'd0) && (cmd_arg_o == 32'd0));
endmodule

bind sd_init_seq sd_init_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_o(cmd_valid_o), .cmd_idx_o(cmd_idx_o),
  .cmd_arg_o(cmd_arg_o), .cmd_rsp_o(cmd_rsp_o), .done_o(done_o), .error_o(error_o),
  .card_type_o(card_type_o), .rca_o(rca_o)
);

// File: tb/sim_sd_init_seq.sv
module sim_sd_init_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmd_valid;
  logic [5:0]   cmd_idx;
  logic [31:0]  cmd_arg;
  logic [1:0]   cmd_rsp;
  logic         cmd_sent = 1'b0, rsp_done = 1'b0, crc_fail = 1'b0, tmo = 1'b0;
  logic [5:0]   rsp_idx = '0;
  logic [127:0] rsp_word = '0;
  logic         done, error;
  logic [1:0]   card_type;
  logic [15:0]  rca;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // scenario knobs
  int s_c8_fail, s_c8_bit8, s_c55_bad, s_a41_fail, s_a41_busy, s_a41_crc, s_a41_ccs;
  int s_c2_fail, s_c3_fail, s_rca, s_poke;

  always #5 clk = ~clk;

  sd_init_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cmd_valid_o(cmd_valid), .cmd_idx_o(cmd_idx), .cmd_arg_o(cmd_arg), .cmd_rsp_o(cmd_rsp),
    .cmd_sent_i(cmd_sent), .rsp_done_i(rsp_done), .crc_fail_i(crc_fail), .timeout_i(tmo),
    .rsp_idx_i(rsp_idx), .rsp_word_i(rsp_word),
    .done_o(done), .error_o(error), .card_type_o(card_type), .rca_o(rca)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_type(int hcs, int ccs);
    if (ccs != 0) return 3;
    return (hcs != 0) ? 2 : 1;
  endfunction

  // a failed reply for a command whose good reply carries index good_idx
  task automatic put_fail(logic [5:0] good_idx, bit crc_allowed);
    int k = int'($urandom % (crc_allowed ? 3 : 2));
    rsp_word = {$urandom, $urandom, $urandom, $urandom};
    rsp_idx  = good_idx;
    if (k == 0) tmo = 1'b1;
    else if (k == 1) begin rsp_done = 1'b1; rsp_idx = good_idx ^ 6'h10; end
    else crc_fail = 1'b1;
  endtask

  task automatic put_good(logic [5:0] idx, logic [31:0] w, bit use_crc);
    rsp_word = {$urandom, $urandom, $urandom, w};
    rsp_idx  = idx;
    if (use_crc) crc_fail = 1'b1; else rsp_done = 1'b1;
  endtask

  task automatic run_scn(string name);
    int hcs = (s_c8_fail < 32) ? s_c8_bit8 : 0;
    int n8 = 0, p55 = 0, n55 = 0, p41 = 0, n41f = 0, n41v = 0, n2 = 0, n3 = 0;
    int nxt = 0;
    int guard = 0;
    bit exp_err;
    exp_err = (s_c8_fail < 32 && s_c8_bit8 == 0) || s_c55_bad >= 32 || s_a41_fail >= 32 ||
              s_c2_fail >= 32 || s_c3_fail >= 32;
    $display("scenario %s", name);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (guard < 4000) begin
      logic [5:0] idx;
      bit fail;
      guard++;
      if (done || error) break;
      chk(cmd_valid == 1'b1, "R13", "strobe one cycle after stimulus", cmd_valid, 1);
      chk(cmd_idx == 6'(nxt), "R2", "command order", cmd_idx, nxt);
      idx = cmd_idx;
      fail = 1'b0;
      case (idx)
        6'd0:  chk(cmd_rsp == 2'd0 && cmd_arg == 0, "R2", "reset cmd kind/arg", {cmd_rsp, cmd_arg}, 0);
        6'd8:  chk(cmd_rsp == 2'd1 && cmd_arg == 32'h1CC, "R2", "if-cond kind/arg",
                   {cmd_rsp, cmd_arg}, {2'd1, 32'h1CC});
        6'd55: chk(cmd_rsp == 2'd1 && cmd_arg == 0, "R5", "prefix kind/arg", {cmd_rsp, cmd_arg}, {2'd1, 32'h0});
        6'd41: chk(cmd_rsp == 2'd1 && cmd_arg == (32'h1000_0000 | (32'(hcs) << 30)), "R6", "op-cond arg",
                   cmd_arg, 32'h1000_0000 | (32'(hcs) << 30));
        6'd2:  chk(cmd_rsp == 2'd3 && cmd_arg == 0, "R9", "ident kind/arg", {cmd_rsp, cmd_arg}, {2'd3, 32'h0});
        default: chk(cmd_rsp == 2'd1 && cmd_arg == 0, "R9", "address kind/arg", {cmd_rsp, cmd_arg}, {2'd1, 32'h0});
      endcase
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R13", "strobe drops", cmd_valid, 0);
      if (s_poke != 0 && guard == 3) begin
        start = 1'b1; @(negedge clk); start = 1'b0;  // R12/R13: must not restart
      end
      repeat ($urandom % 4) @(negedge clk);
      case (idx)
        6'd0: begin cmd_sent = 1'b1; nxt = 8; end
        6'd8: begin
          n8++;
          if (n8 <= s_c8_fail) begin put_fail(6'd8, 1'b1); fail = 1'b1; end
          else put_good(6'd8, ($urandom & ~32'h100) | (32'(s_c8_bit8) << 8), 1'b0);
          if (fail) nxt = (n8 == 32) ? 55 : 8;   // R4
          else nxt = (s_c8_bit8 != 0) ? 55 : 99; // R3
        end
        6'd55: begin
          n55++; p55++;
          if (n55 <= s_c55_bad) begin
            fail = 1'b1;
            if ($urandom % 2 == 0) put_fail(6'd55, 1'b1);
            else put_good(6'd55, $urandom & ~32'h20, 1'b0);
          end else put_good(6'd55, $urandom | 32'h20, 1'b0);
          nxt = fail ? ((p55 == 32) ? 99 : 55) : 41;
          if (!fail) p41 = 0;
        end
        6'd41: begin
          p41++;
          if (n41f < s_a41_fail) begin n41f++; put_fail(6'h3F, 1'b0); fail = 1'b1; end
          else begin
            bit busy = (n41v < s_a41_busy);
            n41v++;
            put_good(6'h3F, ($urandom & 32'h3FFF_FFFF) | (busy ? 32'h0 : 32'h8000_0000) |
                     (32'(s_a41_ccs) << 30), s_a41_crc != 0);
            nxt = busy ? 55 : 2;   // R7
            if (busy) p55 = 0;
          end
          if (fail) nxt = (p41 == 32) ? 99 : 41;
        end
        6'd2: begin
          n2++;
          if (n2 <= s_c2_fail) begin put_fail(6'h3F, 1'b1); fail = 1'b1; end
          else put_good(6'h3F, $urandom, 1'b0);
          nxt = fail ? ((n2 == 32) ? 99 : 2) : 3;
        end
        default: begin
          n3++;
          if (n3 <= s_c3_fail) begin put_fail(6'd3, 1'b1); fail = 1'b1; end
          else put_good(6'd3, {16'(s_rca), 16'($urandom)}, 1'b0);
          nxt = fail ? ((n3 == 32) ? 99 : 3) : 99;
        end
      endcase
      @(negedge clk);
      cmd_sent = 0; rsp_done = 0; crc_fail = 0; tmo = 0;
    end
    chk(nxt == 99, "R10", "sequence ended where expected", nxt, 99);
    if (exp_err) begin
      chk(error == 1'b1 && done == 1'b0, "R11", "error pulse", {done, error}, 1);
      chk(card_type == 0 && rca == 0, "R11", "outputs cleared", {card_type, rca}, 0);
    end else begin
      chk(done == 1'b1 && error == 1'b0, "R12", "done pulse", {done, error}, 2);
      chk(card_type == 2'(exp_type(hcs, s_a41_ccs)), "R8", "card type", card_type, exp_type(hcs, s_a41_ccs));
      chk(rca == 16'(s_rca), "R9", "relative address", rca, s_rca);
    end
    @(negedge clk);
    chk(done == 0 && error == 0 && cmd_valid == 0, "R12", "single-cycle result, idle",
        {cmd_valid, done, error}, 0);
    if (!exp_err)
      chk(card_type == 2'(exp_type(hcs, s_a41_ccs)) && rca == 16'(s_rca), "R12", "result held",
          {card_type, rca}, {2'(exp_type(hcs, s_a41_ccs)), 16'(s_rca)});
  endtask

  task automatic set_scn(int c8f, int b8, int c55, int a41f, int busy, int crc, int ccs,
                         int c2f, int c3f, int r, int poke);
    s_c8_fail = c8f; s_c8_bit8 = b8; s_c55_bad = c55; s_a41_fail = a41f; s_a41_busy = busy;
    s_a41_crc = crc; s_a41_ccs = ccs; s_c2_fail = c2f; s_c3_fail = c3f; s_rca = r; s_poke = poke;
  endtask

  initial begin
    void'($urandom(32'h5D1A_0C3E));
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && done == 0 && error == 0, "R1", "reset strobes", {cmd_valid, done, error}, 0);
    chk(card_type == 0 && rca == 0, "R1", "reset outputs", {card_type, rca}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_valid == 0, "R1", "idle without start", cmd_valid, 0);
    // R3 R6 R8: newer high-capacity card, op-cond replies with CRC failure accepted
    set_scn(0, 1, 0, 0, 2, 1, 1, 0, 0, 16'hB3C1, 0); run_scn("v2_hc");
    // R4: all if-cond attempts fail -> older card, op-cond arg bit 30 clear
    set_scn(32, 1, 0, 0, 1, 0, 0, 0, 0, 16'h0042, 0); run_scn("v1");
    // R5 R10 R13: retries up to 31 failures, start poked mid-run
    set_scn(5, 1, 3, 2, 1, 0, 0, 4, 31, 16'hFFFF, 1); run_scn("v2_sc_retries");
    // R3: valid if-cond reply with bit 8 clear
    set_scn(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); run_scn("ifcond_reject");
    // R5 R11: prefix exhausted
    set_scn(0, 1, 32, 0, 0, 0, 0, 0, 0, 0, 0); run_scn("prefix_exhaust");
    // R6 R11: op-cond exhausted
    set_scn(31, 1, 0, 32, 0, 0, 0, 0, 0, 0, 0); run_scn("opcond_exhaust");
    // R9 R11: address exhausted
    set_scn(0, 1, 0, 0, 0, 0, 0, 0, 32, 0, 0); run_scn("addr_exhaust");
    // R7 R8: constrained random mixes
    for (int i = 0; i < 8; i++) begin
      set_scn(($urandom % 4 == 0) ? 32 : int'($urandom % 6), 1, int'($urandom % 5), int'($urandom % 5),
              int'($urandom % 6), int'($urandom % 2), int'($urandom % 2), int'($urandom % 5),
              int'($urandom % 5), int'($urandom % 65536), int'($urandom % 2));
      run_scn("random");
    end
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule